// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block receives configuration words for a dual frequency synthesizer over a three-wire serial link made of a data line, a shift clock and a load strobe. All three lines are asynchronous to the system clock. They are synchronized, and edges are detected in the system clock domain. Every detected rising edge of the shift clock pushes one data bit into a 23-bit shift register. The word is sent most significant position first, so the two address bits at positions 1 and 2 arrive last.

When the load strobe rises, the two lowest positions of the word pick one of four destination registers: the reference word of synthesizer 1 or 2, or the divider word of synthesizer 1 or 2. The address also decides how the other 21 positions split into fields. The decoded fields of all four registers are presented on output ports at all times. A word that carries a prohibited division ratio below 3 is discarded, so a ratio of 0, 1 or 2 can never appear on an output.

Top module: `route_cfg_loader`

## Requirements
- R1: Each rising edge of `serClk` (after synchronization) shifts `serData` into a 23-bit shift register. The most significant position (position 23) is sent first. When more than 23 bits are sent before a load, only the last 23 are used.
- R2: On a load, position 1 (the last bit sent, address bit A0) and position 2 (address bit A1) select the destination: A1=0,A0=0 is reference 1; A1=0,A0=1 is reference 2; A1=1,A0=0 is divider 1; A1=1,A0=1 is divider 2. A load changes no other register.
- R3: Reference layout: positions 3 and 4 drive `refNTest[0]` and `refNTest[1]`. Positions 5..18 hold the 14-bit ratio, least significant bit at position 5. Position 19 drives `refNPump`. Positions 20..23 are ignored.
- R4: Divider layout: position 3 drives `divNMonSel`, position 4 drives `divNPresc` and position 5 drives `divNPolarity`. Positions 6..12 hold the 7-bit swallow count, least significant bit at position 6. Positions 13..23 hold the 11-bit main count, least significant bit at position 13.
- R5: A load happens only on a rising edge of `serLatch`. While `serLatch` stays at a constant level, with no rising edge, every output holds its value. The falling edge of `serLatch` loads nothing.
- R6: Rising edges of `serClk` that arrive while `serLatch` is high do not change the shift register.
- R7: While `rstN` is low, every output holds its default: ratios and main counts are 3, and swallow counts, test bits, pump, monitor-select, prescaler and polarity bits are 0.
- R8: A reference word whose ratio is below 3, or a divider word whose main count is below 3, leaves its destination unchanged. Ratio and count outputs are therefore never below 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serData | input | 1 | Serial data line |
| serClk | input | 1 | Serial shift clock, sampled on its rising edge |
| serLatch | input | 1 | Load strobe, acts on its rising edge |
| ref1Ratio | output | 14 | Reference ratio, synthesizer 1 |
| ref1Test | output | 2 | Test-select bits, synthesizer 1 |
| ref1Pump | output | 1 | Pump-current select, synthesizer 1 |
| ref2Ratio | output | 14 | Reference ratio, synthesizer 2 |
| ref2Test | output | 2 | Test-select bits, synthesizer 2 |
| ref2Pump | output | 1 | Pump-current select, synthesizer 2 |
| div1Count | output | 11 | Main divider count, synthesizer 1 |
| div1Swallow | output | 7 | Swallow count, synthesizer 1 |
| div1MonSel | output | 1 | Monitor-output select, synthesizer 1 |
| div1Presc | output | 1 | Prescaler modulus select, synthesizer 1 |
| div1Polarity | output | 1 | Phase detector polarity, synthesizer 1 |
| div2Count | output | 11 | Main divider count, synthesizer 2 |
| div2Swallow | output | 7 | Swallow count, synthesizer 2 |
| div2MonSel | output | 1 | Monitor-output select, synthesizer 2 |
| div2Presc | output | 1 | Prescaler modulus select, synthesizer 2 |
| div2Polarity | output | 1 | Phase detector polarity, synthesizer 2 |

## Verification
The bench sends words to all four addresses. It uses minimum and maximum ratios and counts, alternating bit patterns, and distinct values in the single-bit fields, so that a swapped address bit, a shifted field or a reversed bit order shows up as a wrong value on some output. The don't-care positions of reference words are filled with ones to show that they do not leak into any field. Words with a ratio or count of 2 or 0 test the discard rule. A word shifted in while the strobe is held high, followed by a fresh strobe, tests whether those edges were ignored: the old shift contents are reloaded instead. A run of extra leading bits before a word tests that only the last 23 bits count.

// File: rtl/route_cfg_pkg.sv
package route_cfg_pkg;
  parameter int WORD_W    = 23;
  parameter int NUM_SYN   = 2;
  parameter int REF_W     = 14;
  parameter int CNT_W     = 11;
  parameter int SWL_W     = 7;
  parameter int TEST_W    = 2;
  parameter int RATIO_MIN = 3;
  parameter int SYNC_STAGES = 2;

  localparam int SEL_W    = $clog2(NUM_SYN);
  localparam int ADDR_W   = SEL_W + 1;
  // reference word field positions (bit index = position - 1)
  localparam int TEST_LO  = ADDR_W;
  localparam int RATIO_LO = TEST_LO + TEST_W;
  localparam int PUMP_POS = RATIO_LO + REF_W;
  // divider word field positions
  localparam int MON_POS  = ADDR_W;
  localparam int PRESC_POS = MON_POS + 1;
  localparam int POL_POS  = PRESC_POS + 1;
  localparam int SWL_LO   = POL_POS + 1;
  localparam int CNT_LO   = SWL_LO + SWL_W;

  typedef struct packed {
    logic [REF_W-1:0]  ratio;
    logic [TEST_W-1:0] test;
    logic              pump;
  } ref_word_t;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic [SWL_W-1:0] swallow;
    logic             monSel;
    logic             presc;
    logic             polarity;
  } div_word_t;

  typedef struct packed {
    logic shiftEn;
    logic bitVal;
    logic loadEn;
  } strobe_t;
endpackage

// File: rtl/route_cfg_ctrl.sv
module route_cfg_ctrl
  import route_cfg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    serData,
  input  logic    serClk,
  input  logic    serLatch,
  output strobe_t stb
);
  localparam int IDX_DATA  = 0;
  localparam int IDX_CLK   = 1;
  localparam int IDX_LATCH = 2;
  localparam int NUM_LINES = 3;

  logic [NUM_LINES-1:0] syncChain [SYNC_STAGES];
  logic [NUM_LINES-1:0] syncOut;
  logic [NUM_LINES-1:0] syncPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncChain[i] <= '0;
      syncPrev <= '0;
    end else begin
      syncChain[0] <= {serLatch, serClk, serData};
      for (int i = 1; i < SYNC_STAGES; i++) syncChain[i] <= syncChain[i-1];
      syncPrev <= syncChain[SYNC_STAGES-1];
    end
  end

  assign syncOut = syncChain[SYNC_STAGES-1];

  logic clkRise;
  logic latchRise;
  logic latchLevel;

  assign clkRise    = syncOut[IDX_CLK] & ~syncPrev[IDX_CLK];
  assign latchRise  = syncOut[IDX_LATCH] & ~syncPrev[IDX_LATCH];
  assign latchLevel = syncOut[IDX_LATCH] | syncPrev[IDX_LATCH];

  always_comb begin
    stb.bitVal  = syncOut[IDX_DATA];
    stb.shiftEn = clkRise & ~latchLevel;
    stb.loadEn  = latchRise;
  end
endmodule

// File: rtl/route_cfg_dp.sv
module route_cfg_dp
  import route_cfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  output ref_word_t [NUM_SYN-1:0]   refOut,
  output div_word_t [NUM_SYN-1:0]   divOut
);
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (stb.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], stb.bitVal};
  end

  logic [SEL_W-1:0] selSyn;
  logic             isDiv;
  ref_word_t        refCand;
  div_word_t        divCand;
  logic             refOk;
  logic             divOk;

  always_comb begin
    selSyn           = shiftReg[SEL_W-1:0];
    isDiv            = shiftReg[SEL_W];
    refCand.test     = shiftReg[TEST_LO +: TEST_W];
    refCand.ratio    = shiftReg[RATIO_LO +: REF_W];
    refCand.pump     = shiftReg[PUMP_POS];
    divCand.monSel   = shiftReg[MON_POS];
    divCand.presc    = shiftReg[PRESC_POS];
    divCand.polarity = shiftReg[POL_POS];
    divCand.swallow  = shiftReg[SWL_LO +: SWL_W];
    divCand.count    = shiftReg[CNT_LO +: CNT_W];
    refOk            = refCand.ratio >= REF_W'(RATIO_MIN);
    divOk            = divCand.count >= CNT_W'(RATIO_MIN);
  end

  localparam ref_word_t REF_DEFAULT = '{ratio: REF_W'(RATIO_MIN), test: '0, pump: 1'b0};
  localparam div_word_t DIV_DEFAULT = '{count: CNT_W'(RATIO_MIN), swallow: '0,
                                        monSel: 1'b0, presc: 1'b0, polarity: 1'b0};

  for (genvar g = 0; g < NUM_SYN; g++) begin : gSyn
    logic hitRef;
    logic hitDiv;
    assign hitRef = stb.loadEn && !isDiv && (selSyn == SEL_W'(g)) && refOk;
    assign hitDiv = stb.loadEn &&  isDiv && (selSyn == SEL_W'(g)) && divOk;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) refOut[g] <= REF_DEFAULT;
      else if (hitRef) refOut[g] <= refCand;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) divOut[g] <= DIV_DEFAULT;
      else if (hitDiv) divOut[g] <= divCand;
    end
  end
endmodule

// File: rtl/route_cfg_loader.sv
module route_cfg_loader
  import route_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             serData,
  input  logic             serClk,
  input  logic             serLatch,
  output logic [REF_W-1:0] ref1Ratio,
  output logic [1:0]       ref1Test,
  output logic             ref1Pump,
  output logic [REF_W-1:0] ref2Ratio,
  output logic [1:0]       ref2Test,
  output logic             ref2Pump,
  output logic [CNT_W-1:0] div1Count,
  output logic [SWL_W-1:0] div1Swallow,
  output logic             div1MonSel,
  output logic             div1Presc,
  output logic             div1Polarity,
  output logic [CNT_W-1:0] div2Count,
  output logic [SWL_W-1:0] div2Swallow,
  output logic             div2MonSel,
  output logic             div2Presc,
  output logic             div2Polarity
);
  strobe_t                 stb;
  ref_word_t [NUM_SYN-1:0] refOut;
  div_word_t [NUM_SYN-1:0] divOut;

  route_cfg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .serData  (serData),
    .serClk   (serClk),
    .serLatch (serLatch),
    .stb      (stb)
  );

  route_cfg_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .refOut (refOut),
    .divOut (divOut)
  );

  assign ref1Ratio    = refOut[0].ratio;
  assign ref1Test     = refOut[0].test;
  assign ref1Pump     = refOut[0].pump;
  assign ref2Ratio    = refOut[1].ratio;
  assign ref2Test     = refOut[1].test;
  assign ref2Pump     = refOut[1].pump;
  assign div1Count    = divOut[0].count;
  assign div1Swallow  = divOut[0].swallow;
  assign div1MonSel   = divOut[0].monSel;
  assign div1Presc    = divOut[0].presc;
  assign div1Polarity = divOut[0].polarity;
  assign div2Count    = divOut[1].count;
  assign div2Swallow  = divOut[1].swallow;
  assign div2MonSel   = divOut[1].monSel;
  assign div2Presc    = divOut[1].presc;
  assign div2Polarity = divOut[1].polarity;
endmodule

// File: rtl/route_cfg_chk.sv
module route_cfg_chk
  import route_cfg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             serData,
  input logic             serClk,
  input logic             serLatch,
  input logic [REF_W-1:0] ref1Ratio,
  input logic [1:0]       ref1Test,
  input logic             ref1Pump,
  input logic [REF_W-1:0] ref2Ratio,
  input logic [1:0]       ref2Test,
  input logic             ref2Pump,
  input logic [CNT_W-1:0] div1Count,
  input logic [SWL_W-1:0] div1Swallow,
  input logic             div1MonSel,
  input logic             div1Presc,
  input logic             div1Polarity,
  input logic [CNT_W-1:0] div2Count,
  input logic [SWL_W-1:0] div2Swallow,
  input logic             div2MonSel,
  input logic             div2Presc,
  input logic             div2Polarity
);
  logic [16:0] grpRef1, grpRef2;
  logic [20:0] grpDiv1, grpDiv2;
  assign grpRef1 = {ref1Ratio, ref1Test, ref1Pump};
  assign grpRef2 = {ref2Ratio, ref2Test, ref2Pump};
  assign grpDiv1 = {div1Count, div1Swallow, div1MonSel, div1Presc, div1Polarity};
  assign grpDiv2 = {div2Count, div2Swallow, div2MonSel, div2Presc, div2Polarity};

  logic [1:0] rstCycles = 2'd0;
  always @(posedge clk) begin
    if (!rstN) rstCycles <= (rstCycles == 2'd3) ? rstCycles : rstCycles + 2'd1;
    else rstCycles <= 2'd0;
  end

  always @(negedge clk) begin
    if (!rstN && rstCycles != 2'd0) begin
      AST_RESET_DEFAULTS: assert (grpRef1 == {14'd3, 3'd0} && grpRef2 == {14'd3, 3'd0}
        && grpDiv1 == {11'd3, 10'd0} && grpDiv2 == {11'd3, 10'd0}); // R7
    end
  end

  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    ref1Ratio >= 14'd3 && ref2Ratio >= 14'd3); // R8

  AST_COUNT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    div1Count >= 11'd3 && div2Count >= 11'd3); // R8

  AST_HOLD_LATCH_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !serLatch && !$past(serLatch) && !$past(serLatch, 2) && !$past(serLatch, 3)
    |=> $stable({grpRef1, grpRef2, grpDiv1, grpDiv2})); // R5

  AST_HOLD_LATCH_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    serLatch && $past(serLatch) && $past(serLatch, 2) && $past(serLatch, 3)
    |=> $stable({grpRef1, grpRef2, grpDiv1, grpDiv2})); // R6

  AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rstN)
    $countones({grpRef1 != $past(grpRef1), grpRef2 != $past(grpRef2),
                grpDiv1 != $past(grpDiv1), grpDiv2 != $past(grpDiv2)}) <= 1); // R2
endmodule

bind route_cfg_loader route_cfg_chk u_chk (.*);

// File: tb/sim_route_cfg_loader.sv
module sim_route_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serData = 1'b0;
  logic serClk = 1'b0;
  logic serLatch = 1'b0;
  logic [13:0] ref1Ratio, ref2Ratio;
  logic [1:0]  ref1Test, ref2Test;
  logic        ref1Pump, ref2Pump;
  logic [10:0] div1Count, div2Count;
  logic [6:0]  div1Swallow, div2Swallow;
  logic        div1MonSel, div1Presc, div1Polarity;
  logic        div2MonSel, div2Presc, div2Polarity;

  always #(CLK_PERIOD/2) clk = ~clk;

  route_cfg_loader u0 (.*);

  int checkCnt = 0;
  int failCnt  = 0;
  logic [16:0] expRef [2];
  logic [20:0] expDiv [2];

  function automatic logic [22:0] mkRef(input logic sel, input logic [1:0] t,
                                        input logic [13:0] r, input logic cs);
    logic [22:0] w;
    w = '0;
    w[0] = sel; w[1] = 1'b0; w[3:2] = t; w[17:4] = r; w[18] = cs;
    w[22:19] = 4'b1111;
    return w;
  endfunction

  function automatic logic [22:0] mkDiv(input logic sel, input logic mon, input logic ps,
                                        input logic pol, input logic [6:0] a,
                                        input logic [10:0] n);
    logic [22:0] w;
    w = '0;
    w[0] = sel; w[1] = 1'b1; w[2] = mon; w[3] = ps; w[4] = pol;
    w[11:5] = a; w[22:12] = n;
    return w;
  endfunction

  localparam int NVEC = 8;
  localparam logic [22:0] VEC [NVEC] = '{
    mkRef(1'b0, 2'b01, 14'd3,     1'b1),
    mkRef(1'b1, 2'b10, 14'd16383, 1'b0),
    mkDiv(1'b0, 1'b1, 1'b0, 1'b1, 7'd0,   11'd3),
    mkDiv(1'b1, 1'b0, 1'b1, 1'b0, 7'd127, 11'd2047),
    mkRef(1'b0, 2'b11, 14'h2A5A,  1'b0),
    mkDiv(1'b0, 1'b0, 1'b1, 1'b1, 7'h55,  11'h2AA),
    mkRef(1'b1, 2'b00, 14'd1000,  1'b1),
    mkDiv(1'b1, 1'b1, 1'b1, 1'b1, 7'd1,   11'd4)
  };

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [63:0] bits, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      serData = bits[i];
      waitCyc(3);
      serClk = 1'b1;
      waitCyc(3);
      serClk = 1'b0;
      waitCyc(1);
    end
  endtask

  task automatic pulseLatch();
    serLatch = 1'b1;
    waitCyc(4);
    serLatch = 1'b0;
    waitCyc(4);
  endtask

  // model built from R2, R3, R4, R8
  task automatic modelLoad(input logic [22:0] w);
    if (!w[1]) begin
      if (w[17:4] >= 14'd3) expRef[w[0]] = {w[17:4], w[3:2], w[18]};
    end else begin
      if (w[22:12] >= 11'd3) expDiv[w[0]] = {w[22:12], w[11:5], w[2], w[3], w[4]};
    end
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, "ref1", 32'({ref1Ratio, ref1Test, ref1Pump}), 32'(expRef[0]));
    check(req, "ref2", 32'({ref2Ratio, ref2Test, ref2Pump}), 32'(expRef[1]));
    check(req, "div1", 32'({div1Count, div1Swallow, div1MonSel, div1Presc, div1Polarity}),
          32'(expDiv[0]));
    check(req, "div2", 32'({div2Count, div2Swallow, div2MonSel, div2Presc, div2Polarity}),
          32'(expDiv[1]));
  endtask

  task automatic setDefaults();
    expRef[0] = {14'd3, 3'd0};
    expRef[1] = {14'd3, 3'd0};
    expDiv[0] = {11'd3, 10'd0};
    expDiv[1] = {11'd3, 10'd0};
  endtask

  initial begin
    waitCyc(WATCHDOG_CYCLES);
    failCnt++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end

  initial begin
    setDefaults();
    waitCyc(5);
    checkAll("R7_in_reset");
    rstN = 1'b1;
    waitCyc(4);
    checkAll("R7_after_release");

    // table walk: R1 bit order, R2 routing, R3/R4 field positions
    for (int v = 0; v < NVEC; v++) begin
      sendBits(64'(VEC[v]), 23);
      pulseLatch();
      modelLoad(VEC[v]);
      checkAll(VEC[v][1] ? "R4_R2_div" : "R3_R2_ref");
    end

    // R8: prohibited ratio and count are discarded
    sendBits(64'(mkRef(1'b0, 2'b10, 14'd2, 1'b1)), 23);
    pulseLatch();
    checkAll("R8_ratio2");
    sendBits(64'(mkDiv(1'b1, 1'b0, 1'b0, 1'b0, 7'd9, 11'd0)), 23);
    pulseLatch();
    checkAll("R8_count0");

    // R6: shift while latch high is ignored; a new strobe reloads old contents
    sendBits(64'(mkRef(1'b1, 2'b01, 14'd500, 1'b0)), 23);
    pulseLatch();
    modelLoad(mkRef(1'b1, 2'b01, 14'd500, 1'b0));
    checkAll("R6_setup");
    serLatch = 1'b1;
    waitCyc(4);
    sendBits(64'(mkRef(1'b0, 2'b10, 14'd77, 1'b1)), 23);
    serLatch = 1'b0;
    waitCyc(4);
    checkAll("R5_falling_edge");
    pulseLatch();
    modelLoad(mkRef(1'b1, 2'b01, 14'd500, 1'b0));
    checkAll("R6_reload");

    // R5: holding latch high does not reload
    sendBits(64'(mkDiv(1'b0, 1'b1, 1'b0, 1'b0, 7'd3, 11'd100)), 23);
    waitCyc(10);
    checkAll("R5_no_strobe");
    serLatch = 1'b1;
    waitCyc(4);
    modelLoad(mkDiv(1'b0, 1'b1, 1'b0, 1'b0, 7'd3, 11'd100));
    checkAll("R5_strobe");
    sendBits(64'(mkDiv(1'b0, 1'b0, 1'b1, 1'b1, 7'd64, 11'd900)), 23);
    waitCyc(20);
    checkAll("R5_held_high");
    serLatch = 1'b0;
    waitCyc(4);

    // R1: extra leading bits drop out of the register
    sendBits({41'h1F, mkDiv(1'b1, 1'b0, 1'b0, 1'b1, 7'd42, 11'd1234)}, 28);
    pulseLatch();
    modelLoad(mkDiv(1'b1, 1'b0, 1'b0, 1'b1, 7'd42, 11'd1234));
    checkAll("R1_overlong");

    // R7: reset applied again
    rstN = 1'b0;
    waitCyc(3);
    setDefaults();
    checkAll("R7_reassert");

    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end
endmodule